// File: doc/BRIEF.md
# Channel acquisition busy sequencer

This block sequences the acquisition step of a 32-channel hold system. A controller addresses one channel, or all channels at once for calibration, by pulsing an address strobe together with a channel number and a calibrate flag. The sequencer decides when acquisition begins, holds an active-low busy output low for the modelled acquisition time, and then switches the channel's output from the live input to the held value and pulses a done strobe.

The moment acquisition begins depends on the track level seen when the channel is addressed. With track high, acquisition starts at once. With track low, the live input keeps driving the output and the sequencer waits for a rising edge of track, so that a controller can ramp the live input and commit it only once it has reached the wanted level. Acquisition times are whole clock cycles set by parameters, one for a single channel and a longer one for an all-channel calibrate acquisition. A reset request from the track front end aborts any acquisition in progress. An address strobe that arrives while busy is dropped and sets a sticky error flag.

Top module: `hold_acq_sequencer`

## Requirements
- R1: After reset `busy_n_o` is 1, `src_held_o` is 0 (live input selected), and `done_o`, `err_o`, `chan_o` and `all_chan_o` are 0.
- R2: An address strobe accepted while `track_lvl_i` is 1 loads `chan_o` and `all_chan_o` (from the calibrate flag) at the next clock edge and drives `busy_n_o` low from that same edge.
- R3: An address strobe accepted while `track_lvl_i` is 0 keeps `busy_n_o` high and `src_held_o` at 0 until a cycle with `track_rise_i` at 1, after whose clock edge `busy_n_o` goes low; `src_held_o` is 0 whenever `busy_n_o` is 0.
- R4: For a single-channel acquisition (`all_chan_o` = 0), `busy_n_o` stays low for exactly `ONE_CYC` clock cycles.
- R5: For a calibrate acquisition (`all_chan_o` = 1), `busy_n_o` stays low for exactly `CAL_CYC` clock cycles.
- R6: When acquisition completes, `busy_n_o` returns to 1, `done_o` is 1 for exactly that one cycle, and `src_held_o` becomes 1 and stays 1 until the next accepted address strobe.
- R7: An address strobe while `busy_n_o` is 0 is ignored (channel, calibrate flag and remaining duration unchanged) and sets `err_o`, which stays 1 until reset.
- R8: `abort_i` at 1 takes priority over every other input: after that clock edge `busy_n_o` is 1, `src_held_o` is 0, `done_o` is 0, the sequencer is idle, and a strobe in the same cycle is dropped without setting `err_o`.
- R9: `track_rise_i` while no address is pending has no effect on any output.
- R10: A new address strobe while waiting for a track rise is accepted and replaces the pending channel and calibrate flag, re-evaluating `track_lvl_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| abort_i | input | 1 | Reset request from the track front end; aborts and returns to idle |
| addr_stb_i | input | 1 | One-cycle address strobe |
| addr_chan_i | input | CHAN_W | Channel number carried by the strobe |
| addr_cal_i | input | 1 | Calibrate flag: acquire all channels together |
| track_lvl_i | input | 1 | Current track level |
| track_rise_i | input | 1 | One-cycle strobe on a rising edge of track |
| busy_n_o | output | 1 | Low while acquisition runs |
| src_held_o | output | 1 | 1 selects the held value, 0 the live input |
| done_o | output | 1 | One-cycle pulse when acquisition completes |
| err_o | output | 1 | Sticky flag: strobe arrived while busy |
| chan_o | output | CHAN_W | Channel currently targeted |
| all_chan_o | output | 1 | Current target is all channels (calibrate) |

## Verification
Every cycle the assertions check that the source select is live while busy, that done only follows a busy interval and coincides with the held selection, that a busy strobe sets the sticky error and leaves the target untouched, that abort lands in idle, and, through a run-length counter, that each busy interval lasts the duration its calibrate flag selects. Whether a waiting channel starts only on a track rise, whether a rise with nothing pending is really ignored, and how re-addressing during the wait retargets the acquisition can only be shown by the bench's scenarios against its behavioural model.

// File: rtl/hold_acq_pkg.sv
package hold_acq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_ACQ  = 2'd2
   } acq_state_e;
endpackage

// File: rtl/hold_acq_timer.sv
module hold_acq_timer #(
   parameter int ONE_CYC = 1600,
   parameter int CAL_CYC = 4500
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   input  logic all_i,
   output logic expire_o
);
   localparam int MAX_CYC = (CAL_CYC > ONE_CYC) ? CAL_CYC : ONE_CYC;
   localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
   localparam logic [CNT_W-1:0] ONE_LAST = CNT_W'(ONE_CYC - 1);
   localparam logic [CNT_W-1:0] CAL_LAST = CNT_W'(CAL_CYC - 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last;

   // Counts elapsed acquisition cycles; held at zero outside acquisition.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_q <= '0;
      else if (!run_i) cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end

   generate
      if (ONE_CYC == CAL_CYC) begin : g_one_limit
         logic unused_all;
         assign unused_all = all_i;
         assign last = ONE_LAST;
      end else begin : g_two_limits
         assign last = all_i ? CAL_LAST : ONE_LAST;
      end
   endgenerate

   assign expire_o = run_i && (cnt_q == last);
endmodule

// File: rtl/hold_acq_target.sv
module hold_acq_target #(
   parameter int CHAN_W = 5,
   parameter bit CAL_EN = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic [CHAN_W-1:0] chan_i,
   input  logic              cal_i,
   output logic [CHAN_W-1:0] chan_o,
   output logic              all_o
);
   logic cal_eff;

   generate
      if (CAL_EN) begin : g_cal
         assign cal_eff = cal_i;
      end else begin : g_no_cal
         logic unused_cal;
         assign unused_cal = cal_i;
         assign cal_eff = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         chan_o <= '0;
         all_o  <= 1'b0;
      end else if (load_i) begin
         chan_o <= chan_i;
         all_o  <= cal_eff;
      end
   end
endmodule

// File: rtl/hold_acq_sequencer.sv
module hold_acq_sequencer
   import hold_acq_pkg::*;
#(
   parameter int CHANNELS = 32,
   parameter int ONE_CYC  = 1600,
   parameter int CAL_CYC  = 4500,
   parameter bit CAL_EN   = 1'b1,
   localparam int CHAN_W  = (CHANNELS > 1) ? $clog2(CHANNELS) : 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              abort_i,
   input  logic              addr_stb_i,
   input  logic [CHAN_W-1:0] addr_chan_i,
   input  logic              addr_cal_i,
   input  logic              track_lvl_i,
   input  logic              track_rise_i,
   output logic              busy_n_o,
   output logic              src_held_o,
   output logic              done_o,
   output logic              err_o,
   output logic [CHAN_W-1:0] chan_o,
   output logic              all_chan_o
);
   generate
      if (CHANNELS < 2) begin : g_bad_channels
         $error("hold_acq_sequencer: CHANNELS must be at least 2");
      end
      if (ONE_CYC < 1 || CAL_CYC < 1) begin : g_bad_cycles
         $error("hold_acq_sequencer: acquisition durations must be at least 1 cycle");
      end
      if (CAL_EN && CAL_CYC < ONE_CYC) begin : g_bad_cal
         $error("hold_acq_sequencer: CAL_CYC must not be shorter than ONE_CYC");
      end
   endgenerate

   acq_state_e state_q, state_d;
   logic accept, rise_go, expire, finish, busy_hit;
   logic src_q, done_q, err_q;

   always_comb begin
      accept   = addr_stb_i && !abort_i && (state_q != ST_ACQ);
      rise_go  = (state_q == ST_WAIT) && track_rise_i && !addr_stb_i && !abort_i;
      finish   = (state_q == ST_ACQ) && expire && !abort_i;
      busy_hit = addr_stb_i && !abort_i && (state_q == ST_ACQ);
      state_d  = state_q;
      if (abort_i)       state_d = ST_IDLE;
      else if (accept)   state_d = track_lvl_i ? ST_ACQ : ST_WAIT;
      else if (rise_go)  state_d = ST_ACQ;
      else if (finish)   state_d = ST_IDLE;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         src_q   <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= finish;
         if (abort_i || accept) src_q <= 1'b0;
         else if (finish)       src_q <= 1'b1;
         if (busy_hit)          err_q <= 1'b1;
      end
   end

   hold_acq_target #(
      .CHAN_W (CHAN_W),
      .CAL_EN (CAL_EN)
   ) u_target (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (accept),
      .chan_i (addr_chan_i),
      .cal_i  (addr_cal_i),
      .chan_o (chan_o),
      .all_o  (all_chan_o)
   );

   hold_acq_timer #(
      .ONE_CYC (ONE_CYC),
      .CAL_CYC (CAL_CYC)
   ) u_timer (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (state_q == ST_ACQ),
      .all_i    (all_chan_o),
      .expire_o (expire)
   );

   assign busy_n_o   = (state_q != ST_ACQ);
   assign src_held_o = src_q;
   assign done_o     = done_q;
   assign err_o      = err_q;
endmodule

// File: rtl/hold_acq_sequencer_chk.sv
module hold_acq_sequencer_chk #(
   parameter int ONE_CYC = 1600,
   parameter int CAL_CYC = 4500,
   parameter int CHAN_W  = 5
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              abort_i,
   input logic              addr_stb_i,
   input logic              track_lvl_i,
   input logic              busy_n_o,
   input logic              src_held_o,
   input logic              done_o,
   input logic              err_o,
   input logic [CHAN_W-1:0] chan_o,
   input logic              all_chan_o
);
   // Length of the current or just-ended busy interval, in cycles.
   int low_run;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        low_run <= 0;
      else if (busy_n_o)  low_run <= 0;
      else                low_run <= low_run + 1;
   end

   p_start_now_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_n_o && addr_stb_i && track_lvl_i && !abort_i) |=> !busy_n_o);

   p_live_while_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_n_o |-> !src_held_o);

   p_len_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !all_chan_o) |-> (low_run == ONE_CYC));

   p_len_cal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && all_chan_o) |-> (low_run == CAL_CYC));

   p_done_ends_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (busy_n_o && src_held_o && low_run > 0));

   p_busy_strobe_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_n_o && addr_stb_i && !abort_i) |=> err_o);

   p_err_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |=> err_o);

   p_target_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_n_o && !abort_i) |=> ($stable(chan_o) && $stable(all_chan_o)));

   p_abort_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      abort_i |=> (busy_n_o && !done_o && !src_held_o));
endmodule

bind hold_acq_sequencer hold_acq_sequencer_chk #(
   .ONE_CYC (ONE_CYC),
   .CAL_CYC (CAL_CYC),
   .CHAN_W  (CHAN_W)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .abort_i     (abort_i),
   .addr_stb_i  (addr_stb_i),
   .track_lvl_i (track_lvl_i),
   .busy_n_o    (busy_n_o),
   .src_held_o  (src_held_o),
   .done_o      (done_o),
   .err_o       (err_o),
   .chan_o      (chan_o),
   .all_chan_o  (all_chan_o)
);

// File: tb/hold_acq_sequencer_tb.sv
module hold_acq_sequencer_tb;
   localparam int CLK_PERIOD = 10;
   localparam int CHANNELS   = 32;
   localparam int CW         = 5;
   localparam int ONE        = 7;
   localparam int CAL        = 19;
   localparam int WATCHDOG   = 20000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic abort = 1'b0, stb = 1'b0, cal = 1'b0, tlvl = 1'b1, trise = 1'b0;
   logic [CW-1:0] chan_in = '0;
   logic busy_n, held, done, err, all_chan;
   logic [CW-1:0] chan_out;

   int vectors = 0;
   int errors  = 0;
   int cycles  = 0;
   string tag = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   hold_acq_sequencer #(
      .CHANNELS (CHANNELS),
      .ONE_CYC  (ONE),
      .CAL_CYC  (CAL)
   ) u_dut (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .abort_i      (abort),
      .addr_stb_i   (stb),
      .addr_chan_i  (chan_in),
      .addr_cal_i   (cal),
      .track_lvl_i  (tlvl),
      .track_rise_i (trise),
      .busy_n_o     (busy_n),
      .src_held_o   (held),
      .done_o       (done),
      .err_o        (err),
      .chan_o       (chan_out),
      .all_chan_o   (all_chan)
   );

   // Behavioural reference: 0 idle, 1 waiting for track rise, 2 acquiring.
   int m_mode = 0, m_elapsed = 0, m_chan = 0;
   bit m_all = 0, m_held = 0, m_done = 0, m_err = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_mode = 0; m_elapsed = 0; m_chan = 0;
         m_all = 0; m_held = 0; m_done = 0; m_err = 0;
      end else begin
         m_done = 0;
         if (abort) begin
            m_mode = 0; m_held = 0; m_elapsed = 0;
         end else if (m_mode == 2) begin
            if (stb) m_err = 1;
            m_elapsed++;
            if (m_elapsed == (m_all ? CAL : ONE)) begin
               m_mode = 0; m_done = 1; m_held = 1;
            end
         end else if (stb) begin
            m_chan = int'(chan_in); m_all = cal; m_held = 0; m_elapsed = 0;
            m_mode = tlvl ? 2 : 1;
         end else if (m_mode == 1 && trise) begin
            m_mode = 2; m_elapsed = 0;
         end
      end
   end

   task automatic cmp1(string what, int act, int exp);
      vectors++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", tag, what, act, exp, cycles);
      end
   endtask

   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         cmp1("busy_n", int'(busy_n), (m_mode == 2) ? 0 : 1);
         cmp1("src_held", int'(held), int'(m_held));
         cmp1("done", int'(done), int'(m_done));
         cmp1("err", int'(err), int'(m_err));
         cmp1("chan", int'(chan_out), m_chan);
         cmp1("all_chan", int'(all_chan), int'(m_all));
      end
   end

   task automatic step(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic address(int ch, bit c, bit lvl);
      chan_in = CW'(ch); cal = c; tlvl = lvl; stb = 1'b1;
      step(1);
      stb = 1'b0;
   endtask

   task automatic rise;
      tlvl = 1'b1; trise = 1'b1;
      step(1);
      trise = 1'b0;
   endtask

   task automatic pulse_abort;
      abort = 1'b1;
      step(1);
      abort = 1'b0;
   endtask

   initial begin
      // R1: outputs in reset state right after reset release
      step(3);
      rst_n = 1'b1;
      step(2);
      tag = "R1";
      cmp1("reset busy_n", int'(busy_n), 1);
      cmp1("reset src_held", int'(held), 0);
      cmp1("reset err", int'(err), 0);

      // R2 / R4 / R6: track high, single channel acquisition to completion
      tag = "R2";
      address(5, 1'b0, 1'b1);
      cmp1("R2 busy after address", int'(busy_n), 0);
      tag = "R4";
      step(ONE + 2);
      tag = "R6";
      step(3);
      cmp1("R6 held after done", int'(held), 1);

      // R9: track rise with nothing pending
      tag = "R9";
      rise();
      step(3);
      cmp1("R9 idle after stray rise", int'(busy_n), 1);

      // R3: track low at addressing, wait, then rise
      tag = "R3";
      address(9, 1'b0, 1'b0);
      step(6);
      cmp1("R3 still waiting", int'(busy_n), 1);
      rise();
      cmp1("R3 busy after rise", int'(busy_n), 0);
      step(ONE + 3);

      // R5: calibrate acquisition of all channels
      tag = "R5";
      address(0, 1'b1, 1'b1);
      step(CAL + 3);

      // R7: strobe while busy is ignored and flags an error
      tag = "R7";
      address(12, 1'b0, 1'b1);
      step(2);
      address(30, 1'b1, 1'b1);
      cmp1("R7 channel kept", int'(chan_out), 12);
      step(ONE + 3);
      cmp1("R7 err sticky", int'(err), 1);

      // R8: abort mid acquisition, abort while waiting, abort with strobe
      tag = "R8";
      address(3, 1'b0, 1'b1);
      step(3);
      pulse_abort();
      step(ONE + 2);
      address(4, 1'b0, 1'b0);
      step(2);
      pulse_abort();
      rise();
      step(2);
      abort = 1'b1; chan_in = CW'(20); stb = 1'b1; tlvl = 1'b1;
      step(1);
      abort = 1'b0; stb = 1'b0;
      step(3);

      // R10: retarget while waiting for track rise
      tag = "R10";
      address(7, 1'b0, 1'b0);
      step(2);
      address(21, 1'b1, 1'b0);
      cmp1("R10 retargeted", int'(chan_out), 21);
      step(2);
      rise();
      step(CAL + 3);
      address(25, 1'b0, 1'b0);
      step(1);
      address(26, 1'b0, 1'b1);
      step(ONE + 3);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      wait (cycles > WATCHDOG);
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule